// File: doc/BRIEF.md
# Power-Management Event Interrupt Unit

This block keeps the 16-bit event status, event enable and control registers of a power-management function and drives a level-sensitive system control interrupt (SCI) from them. The registers sit in a 64-byte I/O window whose base address and on/off switch come from configuration inputs. Event sources raise status bits with one-cycle pulses, and software clears them by writing ones. A free-running counter acts as the power-management timer.

The SCI is high while at least one of four qualified sources has both its status and its enable bit set. These sources are the timer (bit 0), the global lock (bit 5), the power button (bit 8) and the real-time clock alarm (bit 10). The timer records a status event each time its most significant bit flips. It does so only while that event is armed, meaning its enable bit is set and its status bit is clear.

Top module: `pm_evt_sci`

## Requirements
- R1: After reset the status, enable and control registers read 0, and `sci_o` is low.
- R2: `io_hit_o` is high when `io_addr_i[15:6]` equals `cfg_base_i[15:6]` and `cfg_ctl_i[0]` is 1. Bits 5:0 of `cfg_base_i` take no part in the compare. The window can be moved by changing `cfg_base_i`.
- R3: While `cfg_ctl_i[0]` is 0, or the address falls outside the window, there is no hit. Writes change no register, and reads return 0.
- R4: A write to window offset 0x00 clears each status bit written as 1 and leaves each bit written as 0 unchanged.
- R5: A high bit of `evt_i` sets the matching status bit at the next clock. When a set and a clear of the same bit happen in the same cycle, the set wins.
- R6: `sci_o` is high exactly while status AND enable has a 1 in bit 0, 5, 8 or 10. It follows register changes in the cycle after the clock edge that makes them.
- R7: A status bit outside bits 0, 5, 8 and 10 never raises `sci_o`, even when its enable bit is set.
- R8: The enable register (offset 0x02) and the control register (offset 0x04) are plain 16-bit read/write registers. The status register reads at offset 0x00.
- R9: The timer advances by one each clock. Offset 0x08 reads its low 16 bits and offset 0x0A its upper bits, zero-extended. Writes to the timer are ignored.
- R10: When the timer's top bit flips while enable bit 0 is 1 and status bit 0 is 0, status bit 0 is set.
- R11: A top-bit flip while enable bit 0 is 0 leaves status bit 0 at 0, so the missed event is not recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base_i | input | 16 | Window base configuration; bits 15:6 used |
| cfg_ctl_i | input | 8 | Window control configuration; bit 0 enables decode |
| io_addr_i | input | 16 | I/O access address |
| io_wr_i | input | 1 | Write strobe |
| io_rd_i | input | 1 | Read strobe |
| io_wdata_i | input | 16 | Write data |
| io_rdata_o | output | 16 | Read data, combinational |
| io_hit_o | output | 1 | Address falls in the enabled window |
| evt_i | input | 16 | Event pulses, one per status bit |
| sci_o | output | 1 | System control interrupt level |

## Verification
The hardest case to reach is the timer-arming rule. The flip that matters happens only once every half timer period, and whether it is recorded depends on enable and status state set up long before. The bench builds the timer with a narrow width so a flip comes every 128 cycles. It first waits through two flips with the timer enable clear and confirms no status appears. It then sets only the timer enable and polls until the interrupt rises, which must happen within one half period. A simultaneous event pulse and clearing write is produced by driving both in the same cycle, to show that the set wins.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
  localparam int REG_W   = 16;
  localparam int WIN_LG  = 6;
  localparam logic [WIN_LG-1:0] OFF_STS  = 6'h00;
  localparam logic [WIN_LG-1:0] OFF_EN   = 6'h02;
  localparam logic [WIN_LG-1:0] OFF_CTL  = 6'h04;
  localparam logic [WIN_LG-1:0] OFF_TLO  = 6'h08;
  localparam logic [WIN_LG-1:0] OFF_THI  = 6'h0A;
  localparam int B_TMR = 0;
  localparam int B_GBL = 5;
  localparam int B_PWR = 8;
  localparam int B_RTC = 10;
  localparam logic [REG_W-1:0] SCI_MASK =
    (REG_W'(1) << B_TMR) | (REG_W'(1) << B_GBL) |
    (REG_W'(1) << B_PWR) | (REG_W'(1) << B_RTC);
endpackage

// File: rtl/pm_win_dec.sv
module pm_win_dec #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0]                 base_i,
  input  logic [7:0]                        ctl_i,
  input  logic [ADDR_W-1:0]                 addr_i,
  output logic                              hit_o,
  output logic [pm_evt_pkg::WIN_LG-1:0]     off_o
);
  import pm_evt_pkg::*;
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((1 << WIN_LG) - 1);

  logic [ADDR_W-1:0] base_al;
  logic [ADDR_W-1:0] addr_al;
  logic              win_on;

  always_comb begin
    base_al = base_i & ~LOW_MASK;
    addr_al = addr_i & ~LOW_MASK;
    win_on  = (ctl_i & 8'h01) != 8'h00;
    hit_o   = win_on && (addr_al == base_al);
    off_o   = addr_i[WIN_LG-1:0];
  end
endmodule

// File: rtl/pm_tmr.sv
module pm_tmr #(
  parameter int TMR_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [TMR_W-1:0] cnt_o,
  output logic             flip_o
);
  logic [TMR_W-1:0] cnt_q;
  logic [TMR_W-1:0] cnt_d;

  always_comb begin
    cnt_d  = cnt_q + TMR_W'(1);
    flip_o = &cnt_q[TMR_W-2:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pm_regs.sv
module pm_regs (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_sts_i,
  input  logic                         wr_en_i,
  input  logic                         wr_ctl_i,
  input  logic [pm_evt_pkg::REG_W-1:0] wdata_i,
  input  logic [pm_evt_pkg::REG_W-1:0] evt_i,
  input  logic                         tmr_flip_i,
  output logic [pm_evt_pkg::REG_W-1:0] sts_o,
  output logic [pm_evt_pkg::REG_W-1:0] en_o,
  output logic [pm_evt_pkg::REG_W-1:0] ctl_o,
  output logic                         sci_o
);
  import pm_evt_pkg::*;

  logic [REG_W-1:0] sts_q, en_q, ctl_q;
  logic [REG_W-1:0] set_vec, clr_vec;
  logic             armed, tmr_set;

  always_comb begin
    armed   = en_q[B_TMR] & ~sts_q[B_TMR];
    tmr_set = tmr_flip_i & armed;
    set_vec = evt_i | (REG_W'(tmr_set) << B_TMR);
    clr_vec = wr_sts_i ? wdata_i : '0;
  end

  for (genvar i = 0; i < REG_W; i++) begin : g_sts
    logic bit_d, bit_ce;
    always_comb begin
      bit_ce = set_vec[i] | clr_vec[i];
      bit_d  = set_vec[i] | (sts_q[i] & ~clr_vec[i]);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sts_q[i] <= 1'b0;
      else if (bit_ce) sts_q[i] <= bit_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_q <= '0;
    else if (wr_en_i) en_q <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ctl_q <= '0;
    else if (wr_ctl_i) ctl_q <= wdata_i;
  end

  assign sts_o = sts_q;
  assign en_o  = en_q;
  assign ctl_o = ctl_q;
  assign sci_o = |(sts_q & en_q & SCI_MASK);
endmodule

// File: rtl/pm_evt_sci.sv
module pm_evt_sci #(
  parameter int ADDR_W = 16,
  parameter int TMR_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_base_i,
  input  logic [7:0]        cfg_ctl_i,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic              io_wr_i,
  input  logic              io_rd_i,
  input  logic [15:0]       io_wdata_i,
  output logic [15:0]       io_rdata_o,
  output logic              io_hit_o,
  input  logic [15:0]       evt_i,
  output logic              sci_o
);
  import pm_evt_pkg::*;
  localparam int EXT_W = 2 * REG_W;

  logic [WIN_LG-1:0] off;
  logic              hit;
  logic [TMR_W-1:0]  tmr_cnt;
  logic              tmr_flip;
  logic [EXT_W-1:0]  tmr_ext;
  logic [REG_W-1:0]  sts_q, en_q, ctl_q;
  logic              wr_sts, wr_en, wr_ctl;

  pm_win_dec #(.ADDR_W(ADDR_W)) u_dec (
    .base_i (cfg_base_i),
    .ctl_i  (cfg_ctl_i),
    .addr_i (io_addr_i),
    .hit_o  (hit),
    .off_o  (off)
  );

  pm_tmr #(.TMR_W(TMR_W)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt_o  (tmr_cnt),
    .flip_o (tmr_flip)
  );

  if (TMR_W < EXT_W) begin : g_ext_pad
    assign tmr_ext = {{(EXT_W-TMR_W){1'b0}}, tmr_cnt};
  end else begin : g_ext_full
    assign tmr_ext = tmr_cnt[EXT_W-1:0];
  end

  always_comb begin
    wr_sts = io_wr_i && hit && (off == OFF_STS);
    wr_en  = io_wr_i && hit && (off == OFF_EN);
    wr_ctl = io_wr_i && hit && (off == OFF_CTL);
  end

  pm_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_sts_i   (wr_sts),
    .wr_en_i    (wr_en),
    .wr_ctl_i   (wr_ctl),
    .wdata_i    (io_wdata_i),
    .evt_i      (evt_i),
    .tmr_flip_i (tmr_flip),
    .sts_o      (sts_q),
    .en_o       (en_q),
    .ctl_o      (ctl_q),
    .sci_o      (sci_o)
  );

  always_comb begin
    io_rdata_o = '0;
    if (io_rd_i && hit) begin
      unique case (off)
        OFF_STS: io_rdata_o = sts_q;
        OFF_EN:  io_rdata_o = en_q;
        OFF_CTL: io_rdata_o = ctl_q;
        OFF_TLO: io_rdata_o = tmr_ext[REG_W-1:0];
        OFF_THI: io_rdata_o = tmr_ext[EXT_W-1:REG_W];
        default: io_rdata_o = '0;
      endcase
    end
  end

  assign io_hit_o = hit;
endmodule

// File: rtl/pm_evt_sci_chk.sv
module pm_evt_sci_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  cfg_ctl_i,
  input logic [15:0] io_addr_i,
  input logic        io_wr_i,
  input logic        io_rd_i,
  input logic [15:0] io_wdata_i,
  input logic [15:0] io_rdata_o,
  input logic        io_hit_o,
  input logic [15:0] evt_i,
  input logic        sci_o,
  input logic [15:0] sts_q,
  input logic [15:0] en_q,
  input logic        tmr_flip
);
  p_nohit_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ctl_i[0] |-> !io_hit_o);

  p_rd_miss_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd_i && !io_hit_o) |-> (io_rdata_o == 16'h0000));

  p_w1c_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr_i && io_hit_o && io_addr_i[5:0] == 6'h00 && io_wdata_i == 16'hFFFF
     && evt_i == 16'h0000 && !tmr_flip) |=> (sts_q == 16'h0000));

  p_evt_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != 16'h0000) |=> ((sts_q & $past(evt_i)) == $past(evt_i)));

  p_en_zero_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr_i && io_hit_o && io_addr_i[5:0] == 6'h02 && io_wdata_i == 16'h0000)
    |=> !sci_o);

  p_unqual_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts_q & 16'h0521) == 16'h0000) |-> !sci_o);

  p_armed_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_flip && en_q[0] && !sts_q[0]) |=> sts_q[0]);

  p_disarmed_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_flip && !en_q[0] && !sts_q[0] && !evt_i[0]) |=> !sts_q[0]);
endmodule

bind pm_evt_sci pm_evt_sci_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_ctl_i  (cfg_ctl_i),
  .io_addr_i  (io_addr_i),
  .io_wr_i    (io_wr_i),
  .io_rd_i    (io_rd_i),
  .io_wdata_i (io_wdata_i),
  .io_rdata_o (io_rdata_o),
  .io_hit_o   (io_hit_o),
  .evt_i      (evt_i),
  .sci_o      (sci_o),
  .sts_q      (sts_q),
  .en_q       (en_q),
  .tmr_flip   (tmr_flip)
);

// File: tb/pm_evt_sci_bench.sv
module pm_evt_sci_bench;
  localparam int TW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_base_i = 16'h0000;
  logic [7:0]  cfg_ctl_i = 8'h00;
  logic [15:0] io_addr_i = 16'h0000;
  logic        io_wr_i = 1'b0;
  logic        io_rd_i = 1'b0;
  logic [15:0] io_wdata_i = 16'h0000;
  logic [15:0] io_rdata_o;
  logic        io_hit_o;
  logic [15:0] evt_i = 16'h0000;
  logic        sci_o;

  always #2.5 clk = ~clk;

  pm_evt_sci #(.ADDR_W(16), .TMR_W(TW)) u_pm_evt_sci (.*);

  typedef struct {
    int          kind;
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always begin
    @(negedge clk);
    #1;
    while (sb.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = sb.pop_front();
      case (it.kind)
        0:       act = io_rdata_o;
        1:       act = {15'b0, sci_o};
        default: act = {15'b0, io_hit_o};
      endcase
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    io_addr_i = a; io_wdata_i = d; io_wr_i = 1'b1;
    @(negedge clk);
    io_wr_i = 1'b0;
  endtask

  task automatic rd_chk(input logic [15:0] a, input logic [15:0] e, input string t);
    @(negedge clk);
    io_addr_i = a; io_rd_i = 1'b1;
    sb.push_back('{0, e, t});
    @(negedge clk);
    io_rd_i = 1'b0;
  endtask

  task automatic rd_val(input logic [15:0] a, output logic [15:0] v);
    @(negedge clk);
    io_addr_i = a; io_rd_i = 1'b1;
    #1 v = io_rdata_o;
    @(negedge clk);
    io_rd_i = 1'b0;
  endtask

  task automatic sci_chk(input logic e, input string t);
    @(negedge clk);
    sb.push_back('{1, {15'b0, e}, t});
  endtask

  task automatic hit_chk(input logic [15:0] a, input logic e, input string t);
    @(negedge clk);
    io_addr_i = a;
    sb.push_back('{2, {15'b0, e}, t});
  endtask

  task automatic pulse(input logic [15:0] v);
    @(negedge clk);
    evt_i = v;
    @(negedge clk);
    evt_i = 16'h0000;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [15:0] B;
    int waited;
    bit seen;
    B = 16'hB040;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    sci_chk(1'b0, "R1 sci after reset");
    hit_chk(16'hB040, 1'b0, "R3 no hit before window enable");
    @(negedge clk);
    cfg_base_i = 16'hB047; cfg_ctl_i = 8'h01;
    rd_chk(B + 16'h0, 16'h0000, "R1 status reset");
    rd_chk(B + 16'h2, 16'h0000, "R1 enable reset");
    rd_chk(B + 16'h4, 16'h0000, "R1 control reset");
    hit_chk(16'hB07F, 1'b1, "R2 top of window");
    hit_chk(16'hB080, 1'b0, "R2 above window");
    hit_chk(16'hB03F, 1'b0, "R2 below window");

    wr(B + 16'h2, 16'hFFFE);
    rd_chk(B + 16'h2, 16'hFFFE, "R8 enable readback");
    wr(B + 16'h4, 16'h1234);
    rd_chk(B + 16'h4, 16'h1234, "R8 control readback");

    pulse(16'h0100);
    rd_chk(B, 16'h0100, "R5 power-button event sets bit 8");
    sci_chk(1'b1, "R6 sci from bit 8");
    wr(B, 16'h0000);
    rd_chk(B, 16'h0100, "R4 zero write keeps status");
    sci_chk(1'b1, "R4 sci held after zero write");
    wr(B, 16'h0100);
    rd_chk(B, 16'h0000, "R4 one write clears");
    sci_chk(1'b0, "R6 sci drops after clear");

    pulse(16'h0008);
    rd_chk(B, 16'h0008, "R7 unqualified status recorded");
    sci_chk(1'b0, "R7 unqualified bit gives no sci");
    wr(B, 16'hFFFF);

    pulse(16'h0020);
    sci_chk(1'b1, "R6 sci from bit 5");
    wr(B, 16'h0020);
    sci_chk(1'b0, "R6 sci clear after bit 5");
    pulse(16'h0400);
    sci_chk(1'b1, "R6 sci from bit 10");
    wr(B, 16'h0400);

    @(negedge clk);
    evt_i = 16'h0020; io_addr_i = B; io_wdata_i = 16'h0020; io_wr_i = 1'b1;
    @(negedge clk);
    evt_i = 16'h0000; io_wr_i = 1'b0;
    rd_chk(B, 16'h0020, "R5 set wins over clear");
    wr(B, 16'hFFFF);

    @(negedge clk);
    cfg_ctl_i = 8'h00;
    hit_chk(B + 16'h2, 1'b0, "R3 window disabled no hit");
    wr(B + 16'h2, 16'h0000);
    rd_chk(B + 16'h2, 16'h0000, "R3 read while disabled is zero");
    @(negedge clk);
    cfg_ctl_i = 8'h01;
    rd_chk(B + 16'h2, 16'hFFFE, "R3 disabled write had no effect");

    rd_val(B + 16'h8, v);
    rd_chk(B + 16'h8, (v + 16'd2) & 16'h00FF, "R9 timer advances");
    wr(B + 16'h8, 16'h0055);
    rd_chk(B + 16'h8, (v + 16'd6) & 16'h00FF, "R9 timer write ignored");
    rd_chk(B + 16'hA, 16'h0000, "R9 timer upper bits");

    wr(B, 16'hFFFF);
    repeat (300) @(negedge clk);
    rd_chk(B, 16'h0000, "R11 disarmed flip not recorded");

    wr(B + 16'h2, 16'h0001);
    seen = 1'b0;
    waited = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      #1;
      waited++;
      if (sci_o) begin seen = 1'b1; break; end
    end
    total++;
    if (!seen || waited > (1 << (TW - 1)) + 2) begin
      bad++;
      $display("FAIL R10 timer sci wait actual=%0d expected<=%0d", waited, (1 << (TW - 1)) + 2);
    end
    rd_chk(B, 16'h0001, "R10 armed flip sets timer status");

    @(negedge clk);
    cfg_base_i = 16'h1200;
    hit_chk(B, 1'b0, "R2 old base misses after move");
    rd_chk(16'h1202, 16'h0001, "R2 enable read at new base");

    repeat (3) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule